// File: doc/BRIEF.md
# Set-Associative Page Translator with Protection Faults

This block translates 32-bit virtual addresses through one of two translation buffers. Instruction fetches go through an instruction buffer and loads and stores go through a data buffer. Each buffer has four ways of sixteen entries. An entry is a pair of 32-bit words: a tag word that holds the page number and an address-space tag, and an attribute word that holds the frame number and the global, valid, kernel, write and execute flags. Pages are 8 KB. The low four bits of the page number pick the set, and all four ways of that set are compared at once.

The lookup result is combinational. It gives a hit flag, the physical frame, a read/write/execute grant and an exception vector number. The hit flag is cleared whenever the access faults. On the clock edge of a valid access that faults, and that is not marked as a probe, the block records three things: the set and way into a selection register, the access kind, page and address-space tag into a cause register, and one step of a 16-bit parity-feedback LFSR. On a pure miss, the way to refill is taken from that LFSR. A write port loads entries from software.

Top module: `tlb_xlate`

## Requirements
- R1: The page number is vaddr[31:13] and the set index is vaddr[16:13]. A fetch (req_kind 0) uses the instruction buffer (wr_itlb=1) and has vector base 4. A load (1) or store (2) uses the data buffer and has vector base 8.
- R2: A way matches when tag[31:13] equals the page number and either attr[4] (global) is set or tag[7:0] equals req_asid. When several ways match, the lowest-numbered way wins.
- R3: When no way matches, rsp_hit is 0, rsp_vec is the base vector and rsp_pfn is 0. After any match, rsp_pfn is attr[31:13] of the winning way.
- R4: On a match, faults are ranked as follows. Highest: user access to a kernel page (attr[2]) when cfg_word[18] is set, giving base+2. Next: a store to a page without attr[1] when cfg_word[19] is set, or a fetch from a page without attr[0] when cfg_word[17] is set, giving base+3. Last: an entry without attr[3] when cfg_word[16] is set, giving base+1. A match with no fault gives rsp_hit=1 and the base vector.
- R5: rsp_perm is bit0 read, bit1 write, bit2 execute. On a clean hit it grants read, grants write equal to attr[1], and grants execute only for fetches when cfg_word[17] or attr[0] is set. In every other case it is 0.
- R6: On a recorded fault, sel_reg becomes {way, set} in bits 5:0 (way in 5:4, set in 3:0) with all other bits 0. The way is the matching way on a protection fault and lfsr_q[1:0] before the step on a miss.
- R7: On a recorded fault, cause_reg becomes page number in bits 31:13, cause code in bits 9:8 (execute 0, read 1, write 2, by access kind) and req_asid in bits 7:0, with all other bits 0.
- R8: lfsr_q resets to 0xCCCC. On each recorded fault it steps to {parity(state AND 0x8805), state[15:1]}, and otherwise it holds.
- R9: A fault is recorded only when req_valid is 1 and req_probe is 0. A probe still returns the full lookup result.
- R10: When wr_en is 1, the entry at (wr_itlb buffer, wr_way, wr_set) takes wr_hi/wr_lo at the clock edge, and lookups see it from the next cycle.
- R11: Reset clears sel_reg, cause_reg and every entry to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_user | input | 1 | Access made in user mode |
| req_asid | input | 8 | Current address-space tag |
| req_probe | input | 1 | Lookup only, no recorded side effects |
| cfg_word | input | 32 | Protection enables in bits 19:16 |
| wr_en | input | 1 | Entry write strobe |
| wr_itlb | input | 1 | 1 writes the instruction buffer, 0 the data buffer |
| wr_way | input | 2 | Way to write |
| wr_set | input | 4 | Set to write |
| wr_hi | input | 32 | Tag word |
| wr_lo | input | 32 | Attribute word |
| rsp_hit | output | 1 | Clean hit |
| rsp_pfn | output | 19 | Frame number of the matching way |
| rsp_perm | output | 3 | Granted execute/write/read |
| rsp_vec | output | 4 | Exception vector number |
| sel_reg | output | 32 | Recorded set and way |
| cause_reg | output | 32 | Recorded cause |
| lfsr_q | output | 16 | Refill LFSR state |

## Verification
The first lookups run against the all-zero buffers left by reset, so a tag-zero access must hit. The next lookups check tag agreement against disagreement and a global entry shadowing a lower-priority matching way. Protection fault cases use pairs of entry flags and config enables arranged so that two faults are raised together, which shows which rank wins and that each enable bit switches its own fault off. Sequences of misses with different pages move the refill way through the LFSR states, and probe accesses between them show that nothing is recorded.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int VA_W     = 32;
  localparam int PG_SHIFT = 13;
  localparam int VPN_W    = VA_W - PG_SHIFT;
  localparam int IDX_W    = 4;
  localparam int NSETS    = 1 << IDX_W;
  localparam int NWAYS    = 4;
  localparam int WAY_W    = $clog2(NWAYS);
  localparam int ASID_W   = 8;
  localparam int LFSR_W   = 16;
  localparam int VEC_W    = 4;

  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hCCCC;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'h8805;

  // attribute word flag positions
  localparam int AT_G = 4;
  localparam int AT_V = 3;
  localparam int AT_K = 2;
  localparam int AT_W = 1;
  localparam int AT_X = 0;

  // configuration enable positions
  localparam int CF_V = 16;
  localparam int CF_X = 17;
  localparam int CF_K = 18;
  localparam int CF_W = 19;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_kind_e;

  localparam logic [1:0] CAUSE_EXEC  = 2'd0;
  localparam logic [1:0] CAUSE_READ  = 2'd1;
  localparam logic [1:0] CAUSE_WRITE = 2'd2;

  localparam logic [VEC_W-1:0] IVEC_BASE = 4'd4;
  localparam logic [VEC_W-1:0] DVEC_BASE = 4'd8;
  localparam logic [VEC_W-1:0] VOFS_INV  = 4'd1;
  localparam logic [VEC_W-1:0] VOFS_KERN = 4'd2;
  localparam logic [VEC_W-1:0] VOFS_PROT = 4'd3;

  function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:PG_SHIFT];
  endfunction

  function automatic logic [IDX_W-1:0] set_of(input logic [VPN_W-1:0] vpn);
    return vpn[IDX_W-1:0];
  endfunction

  function automatic logic entry_hits(input logic [31:0] tag, input logic [31:0] attr,
                                      input logic [VPN_W-1:0] vpn,
                                      input logic [ASID_W-1:0] asid);
    return (tag[31:PG_SHIFT] == vpn) && (attr[AT_G] || (tag[ASID_W-1:0] == asid));
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {^(s & LFSR_TAPS), s[LFSR_W-1:1]};
  endfunction

endpackage

// File: rtl/tlb_bank.sv
module tlb_bank
  import tlb_pkg::*;
#(
  parameter int WAYS = NWAYS,
  parameter int SETS = NSETS,
  localparam int WW  = $clog2(WAYS),
  localparam int SW  = $clog2(SETS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [WW-1:0]              wr_way,
  input  logic [SW-1:0]              wr_set,
  input  logic [31:0]                wr_hi,
  input  logic [31:0]                wr_lo,
  input  logic [SW-1:0]              rd_set,
  output logic [WAYS-1:0][31:0]      rd_hi,
  output logic [WAYS-1:0][31:0]      rd_lo
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [31:0] hi_q [SETS];
    logic [31:0] lo_q [SETS];
    logic        wr_here;

    assign wr_here = wr_en && (wr_way == WW'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) begin
          hi_q[s] <= '0;
          lo_q[s] <= '0;
        end
      end else if (wr_here) begin
        hi_q[wr_set] <= wr_hi;
        lo_q[wr_set] <= wr_lo;
      end
    end

    assign rd_hi[w] = hi_q[rd_set];
    assign rd_lo[w] = lo_q[rd_set];
  end

endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match
  import tlb_pkg::*;
#(
  parameter int WAYS = NWAYS,
  localparam int WW  = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][31:0] tag_w,
  input  logic [WAYS-1:0][31:0] attr_w,
  input  logic [VPN_W-1:0]      vpn,
  input  logic [ASID_W-1:0]     asid,
  output logic [WAYS-1:0]       way_hits,
  output logic                  any_hit,
  output logic [WW-1:0]         hit_way,
  output logic [31:0]           hit_attr
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hits[w] = entry_hits(tag_w[w], attr_w[w], vpn, asid);
  end

  // walk from the top so the lowest matching way is left standing
  always_comb begin
    any_hit  = 1'b0;
    hit_way  = '0;
    hit_attr = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hits[w]) begin
        any_hit  = 1'b1;
        hit_way  = WW'(w);
        hit_attr = attr_w[w];
      end
    end
  end

endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_pkg::*;
(
  input  logic             any_hit,
  input  logic [4:0]       flags,
  input  logic [1:0]       kind,
  input  logic             user,
  input  logic [3:0]       cfg_en,
  output logic             grant,
  output logic             flt_kern,
  output logic             flt_prot,
  output logic             flt_inv,
  output logic [2:0]       perm,
  output logic [VEC_W-1:0] vec
);

  logic is_fetch, is_store;
  logic en_v, en_x, en_k, en_w;
  logic [VEC_W-1:0] base;

  assign is_fetch = (kind == ACC_FETCH);
  assign is_store = (kind == ACC_STORE);
  assign en_v     = cfg_en[CF_V - 16];
  assign en_x     = cfg_en[CF_X - 16];
  assign en_k     = cfg_en[CF_K - 16];
  assign en_w     = cfg_en[CF_W - 16];
  assign base     = is_fetch ? IVEC_BASE : DVEC_BASE;

  assign flt_kern = any_hit && en_k && flags[AT_K] && user;
  assign flt_prot = any_hit && ((is_store && en_w && !flags[AT_W]) ||
                                (is_fetch && en_x && !flags[AT_X]));
  assign flt_inv  = any_hit && en_v && !flags[AT_V];
  assign grant    = any_hit && !flt_kern && !flt_prot && !flt_inv;

  always_comb begin
    if (flt_kern)      vec = base + VOFS_KERN;
    else if (flt_prot) vec = base + VOFS_PROT;
    else if (flt_inv)  vec = base + VOFS_INV;
    else               vec = base;
  end

  assign perm = grant ? {is_fetch && (en_x || flags[AT_X]), flags[AT_W], 1'b1} : 3'b000;

endmodule

// File: rtl/tlb_rand_lfsr.sv
module tlb_rand_lfsr
  import tlb_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = LFSR_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [LFSR_W-1:0] state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= lfsr_step(state);
  end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_probe,
  input  logic [31:0]       cfg_word,
  input  logic              wr_en,
  input  logic              wr_itlb,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [IDX_W-1:0]  wr_set,
  input  logic [31:0]       wr_hi,
  input  logic [31:0]       wr_lo,
  output logic              rsp_hit,
  output logic [VPN_W-1:0]  rsp_pfn,
  output logic [2:0]        rsp_perm,
  output logic [VEC_W-1:0]  rsp_vec,
  output logic [31:0]       sel_reg,
  output logic [31:0]       cause_reg,
  output logic [LFSR_W-1:0] lfsr_q
);

  localparam int NBANK = 2;  // bank 0 instruction, bank 1 data

  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] rd_set;
  logic             is_inst;

  assign vpn     = page_of(req_vaddr);
  assign rd_set  = set_of(vpn);
  assign is_inst = (req_kind == ACC_FETCH);

  logic [NBANK-1:0][NWAYS-1:0][31:0] bank_hi, bank_lo;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = wr_en && (wr_itlb == (b == 0));
    tlb_bank #(.WAYS(NWAYS), .SETS(NSETS)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bank_wr),
      .wr_way (wr_way),
      .wr_set (wr_set),
      .wr_hi  (wr_hi),
      .wr_lo  (wr_lo),
      .rd_set (rd_set),
      .rd_hi  (bank_hi[b]),
      .rd_lo  (bank_lo[b])
    );
  end

  logic [NWAYS-1:0][31:0] cur_hi, cur_lo;
  assign cur_hi = is_inst ? bank_hi[0] : bank_hi[1];
  assign cur_lo = is_inst ? bank_lo[0] : bank_lo[1];

  logic [NWAYS-1:0] way_hits;
  logic             any_hit;
  logic [WAY_W-1:0] hit_way;
  logic [31:0]      hit_attr;

  tlb_way_match #(.WAYS(NWAYS)) u_match (
    .tag_w    (cur_hi),
    .attr_w   (cur_lo),
    .vpn      (vpn),
    .asid     (req_asid),
    .way_hits (way_hits),
    .any_hit  (any_hit),
    .hit_way  (hit_way),
    .hit_attr (hit_attr)
  );

  logic grant, flt_kern, flt_prot, flt_inv;

  tlb_perm_check u_perm (
    .any_hit  (any_hit),
    .flags    (hit_attr[4:0]),
    .kind     (req_kind),
    .user     (req_user),
    .cfg_en   (cfg_word[CF_W:CF_V]),
    .grant    (grant),
    .flt_kern (flt_kern),
    .flt_prot (flt_prot),
    .flt_inv  (flt_inv),
    .perm     (rsp_perm),
    .vec      (rsp_vec)
  );

  assign rsp_hit = grant;
  assign rsp_pfn = any_hit ? hit_attr[31:PG_SHIFT] : '0;

  // named events for the checker
  logic             fault_evt;
  logic             miss_evt;
  logic [WAY_W-1:0] log_way;
  logic [1:0]       cause_code;

  assign fault_evt  = req_valid && !req_probe && !grant;
  assign miss_evt   = fault_evt && !any_hit;
  assign log_way    = any_hit ? hit_way : lfsr_q[WAY_W-1:0];
  assign cause_code = is_inst ? CAUSE_EXEC :
                      (req_kind == ACC_STORE) ? CAUSE_WRITE : CAUSE_READ;

  tlb_rand_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (fault_evt),
    .state (lfsr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_reg   <= '0;
      cause_reg <= '0;
    end else if (fault_evt) begin
      sel_reg   <= 32'({log_way, rd_set});
      cause_reg <= {vpn, 3'b000, cause_code, req_asid};
    end
  end

  logic unused_bits;
  assign unused_bits = ^{req_vaddr[PG_SHIFT-1:0], cfg_word[31:CF_W+1], cfg_word[CF_V-1:0],
                         hit_attr[PG_SHIFT-1:5], flt_kern, flt_prot, flt_inv, miss_evt};

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_probe,
  input logic [1:0]        req_kind,
  input logic              rsp_hit,
  input logic [2:0]        rsp_perm,
  input logic [VEC_W-1:0]  rsp_vec,
  input logic [31:0]       sel_reg,
  input logic [31:0]       cause_reg,
  input logic [LFSR_W-1:0] lfsr_q,
  input logic              fault_evt
);

  AST_LFSR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> lfsr_q == {^($past(lfsr_q) & LFSR_TAPS), $past(lfsr_q[LFSR_W-1:1])}); // R8
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_evt |=> $stable(lfsr_q)); // R8
  AST_PROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_probe) |=> ($stable(sel_reg) && $stable(cause_reg))); // R9
  AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sel_reg[31:6] == '0); // R6
  AST_CAUSE_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cause_reg[12:10] == '0); // R7
  AST_NO_GRANT_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_perm == 3'b000); // R5
  AST_READ_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_perm[0]); // R5
  AST_DATA_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && req_kind != ACC_FETCH) |-> !rsp_perm[2]); // R5
  AST_VEC_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vec[3:2] == ((req_kind == ACC_FETCH) ? 2'b01 : 2'b10)); // R1
  AST_HIT_BASE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_vec[1:0] == 2'b00); // R4

endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_probe (req_probe),
  .req_kind  (req_kind),
  .rsp_hit   (rsp_hit),
  .rsp_perm  (rsp_perm),
  .rsp_vec   (rsp_vec),
  .sel_reg   (sel_reg),
  .cause_reg (cause_reg),
  .lfsr_q    (lfsr_q),
  .fault_evt (fault_evt)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic [7:0]  req_asid = '0;
  logic        req_probe = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        wr_en = 1'b0;
  logic        wr_itlb = 1'b0;
  logic [1:0]  wr_way = '0;
  logic [3:0]  wr_set = '0;
  logic [31:0] wr_hi = '0;
  logic [31:0] wr_lo = '0;
  logic        rsp_hit;
  logic [18:0] rsp_pfn;
  logic [2:0]  rsp_perm;
  logic [3:0]  rsp_vec;
  logic [31:0] sel_reg;
  logic [31:0] cause_reg;
  logic [15:0] lfsr_q;

  tlb_xlate i_tlb_xlate (.*);

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_lfsr = 16'hCCCC;
  logic [31:0] exp_sel = '0;
  logic [31:0] exp_cause = '0;

  localparam logic [31:0] CFG_ALL  = 32'h000F_0000;
  localparam logic [31:0] CFG_NOK  = 32'h000B_0000;
  localparam logic [31:0] CFG_VONL = 32'h0001_0000;
  localparam logic [4:0]  FG = 5'h10, FV = 5'h08, FK = 5'h04, FW = 5'h02, FX = 5'h01;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_lfsr(input logic [15:0] s);
    int ones = 0;
    for (int i = 0; i < 16; i++) if (s[i] && (i == 0 || i == 2 || i == 11 || i == 15)) ones++;
    return {ones[0], s[15:1]};
  endfunction

  function automatic logic [31:0] mk_hi(input logic [18:0] vpn, input logic [7:0] asid);
    return {vpn, 5'b0, asid};
  endfunction
  function automatic logic [31:0] mk_lo(input logic [18:0] pfn, input logic [4:0] fl);
    return {pfn, 8'b0, fl};
  endfunction
  function automatic logic [31:0] mk_va(input logic [18:0] vpn);
    return {vpn, 13'h0ABC};
  endfunction

  task automatic put(input logic itlb, input logic [1:0] way, input logic [3:0] set,
                     input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    wr_en = 1'b1; wr_itlb = itlb; wr_way = way; wr_set = set; wr_hi = hi; wr_lo = lo;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic access(input logic [1:0] kind, input logic [18:0] vpn, input logic user,
                        input logic [7:0] asid, input logic [31:0] cfg, input logic probe,
                        input logic e_hit, input logic [3:0] e_vec, input logic [2:0] e_perm,
                        input logic [18:0] e_pfn, input logic [1:0] e_way, input string tag);
    logic [3:0] base;
    logic [1:0] way;
    base = (kind == 2'd0) ? 4'd4 : 4'd8;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = mk_va(vpn); req_kind = kind; req_user = user;
    req_asid = asid; cfg_word = cfg; req_probe = probe;
    #2;
    check({tag, " hit"},  32'(rsp_hit),  32'(e_hit));
    check({tag, " vec"},  32'(rsp_vec),  32'(e_vec));
    check({tag, " perm"}, 32'(rsp_perm), 32'(e_perm));
    check({tag, " pfn"},  32'(rsp_pfn),  32'(e_pfn));
    if (!e_hit && !probe) begin
      way = (e_vec == base) ? exp_lfsr[1:0] : e_way;
      exp_sel   = {26'b0, way, vpn[3:0]};
      exp_cause = {vpn, 3'b0, kind, asid};
      exp_lfsr  = model_lfsr(exp_lfsr);
    end
    @(posedge clk); #2;
    req_valid = 1'b0; req_probe = 1'b0;
    check({tag, " sel"},   sel_reg,          exp_sel);
    check({tag, " cause"}, cause_reg,        exp_cause);
    check({tag, " lfsr"},  32'(lfsr_q),      32'(exp_lfsr));
  endtask

  task automatic t_reset();
    check("R11 sel after reset", sel_reg, 32'h0);
    check("R11 cause after reset", cause_reg, 32'h0);
    check("R8 lfsr seed", 32'(lfsr_q), 32'h0000CCCC);
    // zeroed entries carry page 0 and tag 0, so a probe of page 0 hits
    access(2'd1, 19'h0, 1'b0, 8'h00, 32'h0, 1'b1, 1'b1, 4'd8, 3'b001, 19'h0, 2'd0,
           "R11 R9 zero entry probe");
  endtask

  task automatic t_basic();
    put(1'b0, 2'd2, 4'h5, mk_hi(19'h12345, 8'h21), mk_lo(19'h0ABCD, FV | FW));
    access(2'd1, 19'h12345, 1'b0, 8'h21, CFG_ALL, 1'b0, 1'b1, 4'd8, 3'b011, 19'h0ABCD, 2'd0,
           "R10 R2 R5 load hit");
    access(2'd2, 19'h12345, 1'b0, 8'h21, CFG_ALL, 1'b0, 1'b1, 4'd8, 3'b011, 19'h0ABCD, 2'd0,
           "R5 store hit");
    access(2'd1, 19'h12345, 1'b0, 8'h22, CFG_ALL, 1'b0, 1'b0, 4'd8, 3'b000, 19'h0, 2'd0,
           "R2 R3 R6 R7 R8 tag mismatch miss");
    access(2'd0, 19'h12345, 1'b0, 8'h21, CFG_ALL, 1'b0, 1'b0, 4'd4, 3'b000, 19'h0, 2'd0,
           "R1 fetch looks in instruction buffer");
  endtask

  task automatic t_global();
    put(1'b0, 2'd1, 4'h5, mk_hi(19'h12345, 8'h99), mk_lo(19'h00777, FG | FV));
    access(2'd1, 19'h12345, 1'b0, 8'h22, CFG_ALL, 1'b0, 1'b1, 4'd8, 3'b001, 19'h00777, 2'd0,
           "R2 global ignores tag");
    access(2'd1, 19'h12345, 1'b0, 8'h21, CFG_ALL, 1'b0, 1'b1, 4'd8, 3'b001, 19'h00777, 2'd0,
           "R2 lowest way wins");
    access(2'd2, 19'h12345, 1'b0, 8'h21, CFG_ALL, 1'b0, 1'b0, 4'd11, 3'b000, 19'h00777, 2'd1,
           "R4 R6 R7 store to read-only");
  endtask

  task automatic t_inst();
    put(1'b1, 2'd3, 4'h3, mk_hi(19'h00003, 8'h05), mk_lo(19'h00111, FK | FV));
    access(2'd0, 19'h00003, 1'b1, 8'h05, CFG_ALL, 1'b0, 1'b0, 4'd6, 3'b000, 19'h00111, 2'd3,
           "R4 kernel beats exec");
    access(2'd0, 19'h00003, 1'b0, 8'h05, CFG_ALL, 1'b0, 1'b0, 4'd7, 3'b000, 19'h00111, 2'd3,
           "R4 exec fault");
    access(2'd0, 19'h00003, 1'b1, 8'h05, CFG_NOK, 1'b0, 1'b0, 4'd7, 3'b000, 19'h00111, 2'd3,
           "R4 kernel enable off");
    access(2'd0, 19'h00003, 1'b0, 8'h05, CFG_VONL, 1'b0, 1'b1, 4'd4, 3'b001, 19'h00111, 2'd0,
           "R5 fetch no exec grant");
    put(1'b1, 2'd0, 4'h7, mk_hi(19'h00007, 8'h05), mk_lo(19'h00222, FV | FX));
    access(2'd0, 19'h00007, 1'b0, 8'h05, CFG_ALL, 1'b0, 1'b1, 4'd4, 3'b101, 19'h00222, 2'd0,
           "R5 fetch exec grant");
    access(2'd0, 19'h00007, 1'b0, 8'h05, 32'h0, 1'b0, 1'b1, 4'd4, 3'b101, 19'h00222, 2'd0,
           "R5 exec from entry bit");
  endtask

  task automatic t_data_faults();
    put(1'b0, 2'd0, 4'h9, mk_hi(19'h00009, 8'h05), mk_lo(19'h00333, FW));
    access(2'd1, 19'h00009, 1'b0, 8'h05, CFG_ALL, 1'b0, 1'b0, 4'd9, 3'b000, 19'h00333, 2'd0,
           "R4 invalid fault");
    access(2'd1, 19'h00009, 1'b0, 8'h05, 32'h0, 1'b0, 1'b1, 4'd8, 3'b011, 19'h00333, 2'd0,
           "R4 valid enable off");
    put(1'b0, 2'd3, 4'hA, mk_hi(19'h0000A, 8'h05), mk_lo(19'h00444, FK));
    access(2'd2, 19'h0000A, 1'b1, 8'h05, CFG_ALL, 1'b0, 1'b0, 4'd10, 3'b000, 19'h00444, 2'd3,
           "R4 kernel beats write");
    access(2'd2, 19'h0000A, 1'b1, 8'h05, CFG_NOK, 1'b0, 1'b0, 4'd11, 3'b000, 19'h00444, 2'd3,
           "R4 write beats invalid");
    access(2'd1, 19'h0000A, 1'b0, 8'h05, CFG_NOK, 1'b0, 1'b0, 4'd9, 3'b000, 19'h00444, 2'd3,
           "R4 invalid after kernel off");
    put(1'b0, 2'd0, 4'hB, mk_hi(19'h0000B, 8'h05), mk_lo(19'h00555, FV | FX | FW));
    access(2'd1, 19'h0000B, 1'b0, 8'h05, CFG_ALL, 1'b0, 1'b1, 4'd8, 3'b011, 19'h00555, 2'd0,
           "R5 data never executes");
  endtask

  task automatic t_probe_and_refill();
    access(2'd1, 19'h55555, 1'b0, 8'h05, CFG_ALL, 1'b1, 1'b0, 4'd8, 3'b000, 19'h0, 2'd0,
           "R9 probe data miss quiet");
    access(2'd0, 19'h55555, 1'b0, 8'h05, CFG_ALL, 1'b1, 1'b0, 4'd4, 3'b000, 19'h0, 2'd0,
           "R9 probe fetch miss quiet");
    for (int i = 0; i < 8; i++) begin
      access(2'(i % 3), 19'h40000 + 19'(i * 19'h111), 1'b0, 8'(8'h30 + i), CFG_ALL, 1'b0,
             1'b0, (i % 3 == 0) ? 4'd4 : 4'd8, 3'b000, 19'h0, 2'd0, "R6 R8 miss refill way");
    end
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #3;
    t_reset();
    t_basic();
    t_global();
    t_inst();
    t_data_faults();
    t_probe_and_refill();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule